// File: doc/BRIEF.md
# Handshake Bus Pipeline Slice

This block sits across an initiator-to-target bus and cuts the long combinational paths that run through request and acknowledge wiring. It has two independent channels. The request channel carries payloads from the initiator to the target. The response channel carries payloads from the target back to the initiator. Both channels use a valid/ready handshake. A transfer happens on a rising clock edge when valid and ready are both high. A source that raises valid keeps it up and holds its data until ready is seen. Ready may fall at any time, and that back-pressure travels upstream through the slice.

Each channel is set at elaboration to one of three variants. The registered variant drives upstream ready from stored occupancy only, so no path runs from downstream ready to upstream ready. The pass-acknowledge variant lets downstream ready reach upstream ready in the same cycle. This reaches full rate with one storage level fewer than the registered variant. The wire variant has no storage at all. Each channel also has its own depth. Stored entries leave in the order they arrived. The reset is synchronous and active high.

Top module: `pb_bus_slice`

## Requirements
- R1: While reset is asserted, both buffered channels empty. On the first edge after reset has been applied, the downstream valid output of each buffered channel is low.
- R2: In a buffered channel, a downstream valid that is not accepted stays high on the next cycle, with unchanged data. Entries leave in arrival order, with none lost and none duplicated.
- R3: In the registered variant, upstream ready is high exactly when fewer than DEPTH entries are held, whatever downstream ready does in that cycle. Occupancy never exceeds DEPTH.
- R4: In a buffered channel, downstream valid is high exactly when at least one entry is held, and downstream data is the oldest held entry.
- R5: In the pass-acknowledge variant, upstream ready is high when fewer than DEPTH entries are held or downstream ready is high. A full buffer therefore takes a new entry in the same cycle it releases one.
- R6: In the wire variant, downstream valid and data equal upstream valid and data, and upstream ready equals downstream ready, all in the same cycle.
- R7: With upstream valid and downstream ready both held high, a registered channel of depth 1 accepts one entry every two cycles. A registered channel of depth 2 or more, a pass-acknowledge channel of any depth, and a wire channel each accept one entry per cycle.
- R8: Starting from a steady full-rate stream, a single cycle of downstream stall in a registered channel causes exactly one cycle of low upstream ready at depth 2, and none at depth 3 or more.
- R9: Under the same single-cycle stall, a pass-acknowledge channel of depth 1 drops upstream ready in that same cycle, for that one cycle only. At depth 2 upstream ready stays high.
- R10: Variant and depth are chosen separately for the request and response channels, and each channel behaves by its own settings only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ini_req_valid | input | 1 | Initiator offers a request |
| ini_req_data | input | REQ_W | Request payload from the initiator |
| ini_req_ready | output | 1 | Slice accepts the request |
| tgt_req_valid | output | 1 | Slice offers a request to the target |
| tgt_req_data | output | REQ_W | Request payload to the target |
| tgt_req_ready | input | 1 | Target accepts the request |
| tgt_rsp_valid | input | 1 | Target offers a response |
| tgt_rsp_data | input | RSP_W | Response payload from the target |
| tgt_rsp_ready | output | 1 | Slice accepts the response |
| ini_rsp_valid | output | 1 | Slice offers a response to the initiator |
| ini_rsp_data | output | RSP_W | Response payload to the initiator |
| ini_rsp_ready | input | 1 | Initiator accepts the response |

## Verification
The bench targets four weak points.

- **Full-buffer handover.** A pass-acknowledge channel must push into a full buffer while it pops. A design that gates ready on not-full alone would halve its rate, and a design that mishandles the shared slot would corrupt or repeat data.
- **Registered ready.** Upstream ready must follow occupancy only. A version that leaks downstream ready into it, or tests full one entry early or late, shows wrong ready cycles or overflows.
- **Depth 1 in the registered variant.** This depth must alternate accept and release. A miscounted occupancy would either claim full rate or stall.
- **Single stall at depths 2 and 3.** The exact number of upstream not-ready cycles shows whether the occupancy bookkeeping absorbs stalls as it should.

// File: rtl/pb_slice_pkg.sv
package pb_slice_pkg;

  // Channel variant, fixed at elaboration
  typedef enum logic [1:0] {
    CH_REGISTERED = 2'd0,  // upstream ready from stored occupancy only
    CH_PASSACK    = 2'd1,  // downstream ready may reach upstream ready
    CH_WIRE       = 2'd2   // straight wiring, no storage
  } chan_mode_e;

endpackage

// File: rtl/pb_fifo_store.sv
module pb_fifo_store #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic                         pop,
  input  logic [W-1:0]                 wdata,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   occ
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ_q;

  function automatic logic [PW-1:0] ptr_step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ_q  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_step(wr_ptr);
      if (pop)  rd_ptr <= ptr_step(rd_ptr);
      case ({push, pop})
        2'b10:   occ_q <= occ_q + CW'(1);
        2'b01:   occ_q <= occ_q - CW'(1);
        default: occ_q <= occ_q;
      endcase
    end
  end

  // Payload cells carry no reset; only pointers and count do
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  assign rdata = mem[rd_ptr];
  assign occ   = occ_q;

endmodule

// File: rtl/pb_channel.sv
module pb_channel
  import pb_slice_pkg::*;
#(
  parameter int         W     = 16,
  parameter int         DEPTH = 2,
  parameter chan_mode_e MODE  = CH_REGISTERED
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  input  logic [W-1:0] up_data,
  output logic         up_ready,
  output logic         dn_valid,
  output logic [W-1:0] dn_data,
  input  logic         dn_ready
);

  localparam int CW = $clog2(DEPTH + 1);

  generate
    if (MODE == CH_WIRE) begin : g_wire
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst;
      assign dn_valid = up_valid;
      assign dn_data  = up_data;
      assign up_ready = dn_ready;
    end else begin : g_buf
      logic [CW-1:0] occ;
      logic          full, empty, push, pop;

      pb_fifo_store #(.W(W), .DEPTH(DEPTH)) i_store (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .wdata (up_data),
        .rdata (dn_data),
        .occ   (occ)
      );

      assign full     = (occ == CW'(DEPTH));
      assign empty    = (occ == '0);
      assign dn_valid = !empty;
      assign pop      = dn_valid && dn_ready;

      if (MODE == CH_REGISTERED) begin : g_reg
        assign up_ready = !full;
      end else begin : g_pass
        // a full buffer frees its head slot in this cycle when downstream takes it
        assign up_ready = !full || dn_ready;
      end

      assign push = up_valid && up_ready;
    end
  endgenerate

endmodule

// File: rtl/pb_bus_slice.sv
module pb_bus_slice
  import pb_slice_pkg::*;
#(
  parameter int         REQ_W     = 16,
  parameter int         RSP_W     = 16,
  parameter int         REQ_DEPTH = 2,
  parameter int         RSP_DEPTH = 1,
  parameter chan_mode_e REQ_MODE  = CH_REGISTERED,
  parameter chan_mode_e RSP_MODE  = CH_PASSACK
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ini_req_valid,
  input  logic [REQ_W-1:0] ini_req_data,
  output logic             ini_req_ready,
  output logic             tgt_req_valid,
  output logic [REQ_W-1:0] tgt_req_data,
  input  logic             tgt_req_ready,
  input  logic             tgt_rsp_valid,
  input  logic [RSP_W-1:0] tgt_rsp_data,
  output logic             tgt_rsp_ready,
  output logic             ini_rsp_valid,
  output logic [RSP_W-1:0] ini_rsp_data,
  input  logic             ini_rsp_ready
);

  // Request path: initiator -> target
  pb_channel #(.W(REQ_W), .DEPTH(REQ_DEPTH), .MODE(REQ_MODE)) i_req_chan (
    .clk      (clk),
    .rst      (rst),
    .up_valid (ini_req_valid),
    .up_data  (ini_req_data),
    .up_ready (ini_req_ready),
    .dn_valid (tgt_req_valid),
    .dn_data  (tgt_req_data),
    .dn_ready (tgt_req_ready)
  );

  // Response path: target -> initiator
  pb_channel #(.W(RSP_W), .DEPTH(RSP_DEPTH), .MODE(RSP_MODE)) i_rsp_chan (
    .clk      (clk),
    .rst      (rst),
    .up_valid (tgt_rsp_valid),
    .up_data  (tgt_rsp_data),
    .up_ready (tgt_rsp_ready),
    .dn_valid (ini_rsp_valid),
    .dn_data  (ini_rsp_data),
    .dn_ready (ini_rsp_ready)
  );

endmodule

// File: rtl/pb_bus_slice_chk.sv
module pb_chan_chk
  import pb_slice_pkg::*;
#(
  parameter int         W     = 16,
  parameter int         DEPTH = 2,
  parameter chan_mode_e MODE  = CH_REGISTERED
) (
  input logic         clk,
  input logic         rst,
  input logic         up_valid,
  input logic [W-1:0] up_data,
  input logic         up_ready,
  input logic         dn_valid,
  input logic [W-1:0] dn_data,
  input logic         dn_ready
);

  localparam int OW = $clog2(DEPTH + 2) + 1;

  generate
    if (MODE == CH_WIRE) begin : g_wire
      p_wire_through_r6: assert property (@(posedge clk) disable iff (rst)
        (dn_valid == up_valid) && (dn_data == up_data) && (up_ready == dn_ready));
    end else begin : g_buf
      logic          unused_chk;
      logic [OW-1:0] occ_q;
      logic          rst_q;

      assign unused_chk = ^up_data;

      // Occupancy rebuilt from port handshakes only
      always_ff @(posedge clk) begin
        if (rst) occ_q <= '0;
        else     occ_q <= occ_q + OW'(up_valid && up_ready) - OW'(dn_valid && dn_ready);
      end

      always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst_q) begin
          p_empty_after_rst_r1: assert (!dn_valid);
        end
      end

      p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

      p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        occ_q <= OW'(DEPTH));

      p_valid_occ_r4: assert property (@(posedge clk) disable iff (rst)
        dn_valid == (occ_q != '0));

      if (MODE == CH_REGISTERED) begin : g_reg
        p_ready_occ_r3: assert property (@(posedge clk) disable iff (rst)
          up_ready == (occ_q < OW'(DEPTH)));
      end else begin : g_pass
        p_passack_r5: assert property (@(posedge clk) disable iff (rst)
          dn_ready |-> up_ready);
      end
    end
  endgenerate

endmodule

module pb_bus_slice_chk
  import pb_slice_pkg::*;
#(
  parameter int         REQ_W     = 16,
  parameter int         RSP_W     = 16,
  parameter int         REQ_DEPTH = 2,
  parameter int         RSP_DEPTH = 1,
  parameter chan_mode_e REQ_MODE  = CH_REGISTERED,
  parameter chan_mode_e RSP_MODE  = CH_PASSACK
) (
  input logic             clk,
  input logic             rst,
  input logic             ini_req_valid,
  input logic [REQ_W-1:0] ini_req_data,
  input logic             ini_req_ready,
  input logic             tgt_req_valid,
  input logic [REQ_W-1:0] tgt_req_data,
  input logic             tgt_req_ready,
  input logic             tgt_rsp_valid,
  input logic [RSP_W-1:0] tgt_rsp_data,
  input logic             tgt_rsp_ready,
  input logic             ini_rsp_valid,
  input logic [RSP_W-1:0] ini_rsp_data,
  input logic             ini_rsp_ready
);

  pb_chan_chk #(.W(REQ_W), .DEPTH(REQ_DEPTH), .MODE(REQ_MODE)) i_req_chk (
    .clk(clk), .rst(rst),
    .up_valid(ini_req_valid), .up_data(ini_req_data), .up_ready(ini_req_ready),
    .dn_valid(tgt_req_valid), .dn_data(tgt_req_data), .dn_ready(tgt_req_ready)
  );

  pb_chan_chk #(.W(RSP_W), .DEPTH(RSP_DEPTH), .MODE(RSP_MODE)) i_rsp_chk (
    .clk(clk), .rst(rst),
    .up_valid(tgt_rsp_valid), .up_data(tgt_rsp_data), .up_ready(tgt_rsp_ready),
    .dn_valid(ini_rsp_valid), .dn_data(ini_rsp_data), .dn_ready(ini_rsp_ready)
  );

endmodule

bind pb_bus_slice pb_bus_slice_chk #(
  .REQ_W(REQ_W), .RSP_W(RSP_W), .REQ_DEPTH(REQ_DEPTH), .RSP_DEPTH(RSP_DEPTH),
  .REQ_MODE(REQ_MODE), .RSP_MODE(RSP_MODE)
) i_chk (
  .clk(clk), .rst(rst),
  .ini_req_valid(ini_req_valid), .ini_req_data(ini_req_data), .ini_req_ready(ini_req_ready),
  .tgt_req_valid(tgt_req_valid), .tgt_req_data(tgt_req_data), .tgt_req_ready(tgt_req_ready),
  .tgt_rsp_valid(tgt_rsp_valid), .tgt_rsp_data(tgt_rsp_data), .tgt_rsp_ready(tgt_rsp_ready),
  .ini_rsp_valid(ini_rsp_valid), .ini_rsp_data(ini_rsp_data), .ini_rsp_ready(ini_rsp_ready)
);

// File: tb/pb_chan_bench.sv
// Drives one channel of the slice and compares it, every cycle, to a queue model.
module pb_chan_bench
  import pb_slice_pkg::*;
#(
  parameter int         W     = 16,
  parameter int         DEPTH = 2,
  parameter chan_mode_e MODE  = CH_REGISTERED
) (
  input  logic         clk,
  input  logic         rst,
  output logic         up_valid,
  output logic [W-1:0] up_data,
  input  logic         up_ready,
  input  logic         dn_valid,
  input  logic [W-1:0] dn_data,
  output logic         dn_ready,
  output int           n_cmp,
  output int           n_bad,
  output logic         done
);

  logic [W-1:0] q [$];
  int seq;

  function automatic string ready_tag();
    if (MODE == CH_REGISTERED) return "R3";
    if (MODE == CH_PASSACK)    return "R5";
    return "R6";
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s in %m at %0t: got %0d expected %0d", tag, what, $time, act, exp);
    end
  endtask

  // Per-cycle comparison against the queue model
  task automatic compare_cycle();
    int ev, er, ed;
    if (MODE == CH_WIRE) begin
      ev = int'(up_valid); ed = int'(up_data); er = int'(dn_ready);
      check("R6", "dn_valid", int'(dn_valid), ev);
      check("R6", "dn_data",  int'(dn_data),  ed);
      check("R6", "up_ready", int'(up_ready), er);
    end else begin
      ev = (q.size() != 0) ? 1 : 0;
      if (MODE == CH_REGISTERED) er = (q.size() < DEPTH) ? 1 : 0;
      else                       er = ((q.size() < DEPTH) || dn_ready) ? 1 : 0;
      check("R4", "dn_valid", int'(dn_valid), ev);
      check(ready_tag(), "up_ready", int'(up_ready), er);
      if (ev != 0) check("R2", "dn_data order", int'(dn_data), int'(q[0]));
    end
  endtask

  task automatic drive(input logic v, input logic r);
    @(negedge clk);
    up_valid = v;
    dn_ready = r;
    up_data  = W'(seq);
    #1;
    compare_cycle();
  endtask

  // Model update on the edge: pop head, append accepted payload
  always @(posedge clk) begin
    if (rst) begin
      q.delete();
    end else begin
      if (up_valid && up_ready) seq++;
      if (MODE != CH_WIRE) begin
        if (dn_valid && dn_ready) void'(q.pop_front());
        if (up_valid && up_ready) q.push_back(up_data);
      end
    end
  end

  initial begin
    int acc, lows, exp_acc;
    n_cmp = 0; n_bad = 0; done = 1'b0; seq = 1;
    up_valid = 1'b0; dn_ready = 1'b1; up_data = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "dn_valid in reset", int'(dn_valid), 0);
    wait (!rst);

    // R2 R4: random traffic, then stall-heavy traffic
    repeat (600) drive(($urandom % 4) != 0, ($urandom % 3) != 0);
    repeat (300) drive(($urandom % 2) != 0, ($urandom % 4) == 0);
    repeat (DEPTH + 4) drive(1'b0, 1'b1);

    // R7: sustained rate with no stalls
    acc = 0;
    for (int i = 0; i < 50; i++) begin
      drive(1'b1, 1'b1);
      if (i >= 10 && up_valid && up_ready) acc++;
    end
    exp_acc = (MODE == CH_REGISTERED && DEPTH == 1) ? 20 : 40;
    check("R7", "accepted in 40 cycles", acc, exp_acc);
    repeat (DEPTH + 4) drive(1'b0, 1'b1);

    // R8 R9: one downstream stall cycle inside a stream
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      drive(1'b1, i != 10);
      if (i >= 5 && !up_ready) lows++;
    end
    if (MODE == CH_REGISTERED && DEPTH >= 2)
      check("R8", "upstream stall cycles", lows, (DEPTH == 2) ? 1 : 0);
    else if (MODE == CH_PASSACK)
      check("R9", "upstream stall cycles", lows, (DEPTH == 1) ? 1 : 0);
    else if (MODE == CH_WIRE)
      check("R6", "upstream stall cycles", lows, 1);
    repeat (DEPTH + 4) drive(1'b0, 1'b1);

    done = 1'b1;
  end

endmodule

// File: tb/test_pb_bus_slice.sv
module test_pb_bus_slice;
  import pb_slice_pkg::*;

  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic timeout = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  // Per-instance wiring: a_ (req REG d2, rsp PASSACK d1), b_ (req REG d1, rsp WIRE),
  // c_ (req REG d3, rsp PASSACK d2). R10: each channel follows its own settings.
  logic         a_qv, a_qr, a_tv, a_tr, a_sv, a_sr, a_iv, a_ir;
  logic [W-1:0] a_qd, a_td, a_sd, a_id;
  logic         b_qv, b_qr, b_tv, b_tr, b_sv, b_sr, b_iv, b_ir;
  logic [W-1:0] b_qd, b_td, b_sd, b_id;
  logic         c_qv, c_qr, c_tv, c_tr, c_sv, c_sr, c_iv, c_ir;
  logic [W-1:0] c_qd, c_td, c_sd, c_id;

  int   cmp [6];
  int   bad [6];
  logic dn  [6];

  pb_bus_slice #(.REQ_W(W), .RSP_W(W), .REQ_DEPTH(2), .RSP_DEPTH(1),
                 .REQ_MODE(CH_REGISTERED), .RSP_MODE(CH_PASSACK)) i_pb_bus_slice (
    .clk(clk), .rst(rst),
    .ini_req_valid(a_qv), .ini_req_data(a_qd), .ini_req_ready(a_qr),
    .tgt_req_valid(a_tv), .tgt_req_data(a_td), .tgt_req_ready(a_tr),
    .tgt_rsp_valid(a_sv), .tgt_rsp_data(a_sd), .tgt_rsp_ready(a_sr),
    .ini_rsp_valid(a_iv), .ini_rsp_data(a_id), .ini_rsp_ready(a_ir)
  );

  pb_bus_slice #(.REQ_W(W), .RSP_W(W), .REQ_DEPTH(1), .RSP_DEPTH(1),
                 .REQ_MODE(CH_REGISTERED), .RSP_MODE(CH_WIRE)) i_pb_bus_slice_b (
    .clk(clk), .rst(rst),
    .ini_req_valid(b_qv), .ini_req_data(b_qd), .ini_req_ready(b_qr),
    .tgt_req_valid(b_tv), .tgt_req_data(b_td), .tgt_req_ready(b_tr),
    .tgt_rsp_valid(b_sv), .tgt_rsp_data(b_sd), .tgt_rsp_ready(b_sr),
    .ini_rsp_valid(b_iv), .ini_rsp_data(b_id), .ini_rsp_ready(b_ir)
  );

  pb_bus_slice #(.REQ_W(W), .RSP_W(W), .REQ_DEPTH(3), .RSP_DEPTH(2),
                 .REQ_MODE(CH_REGISTERED), .RSP_MODE(CH_PASSACK)) i_pb_bus_slice_c (
    .clk(clk), .rst(rst),
    .ini_req_valid(c_qv), .ini_req_data(c_qd), .ini_req_ready(c_qr),
    .tgt_req_valid(c_tv), .tgt_req_data(c_td), .tgt_req_ready(c_tr),
    .tgt_rsp_valid(c_sv), .tgt_rsp_data(c_sd), .tgt_rsp_ready(c_sr),
    .ini_rsp_valid(c_iv), .ini_rsp_data(c_id), .ini_rsp_ready(c_ir)
  );

  pb_chan_bench #(.W(W), .DEPTH(2), .MODE(CH_REGISTERED)) i_a_req (
    .clk(clk), .rst(rst), .up_valid(a_qv), .up_data(a_qd), .up_ready(a_qr),
    .dn_valid(a_tv), .dn_data(a_td), .dn_ready(a_tr),
    .n_cmp(cmp[0]), .n_bad(bad[0]), .done(dn[0]));
  pb_chan_bench #(.W(W), .DEPTH(1), .MODE(CH_PASSACK)) i_a_rsp (
    .clk(clk), .rst(rst), .up_valid(a_sv), .up_data(a_sd), .up_ready(a_sr),
    .dn_valid(a_iv), .dn_data(a_id), .dn_ready(a_ir),
    .n_cmp(cmp[1]), .n_bad(bad[1]), .done(dn[1]));
  pb_chan_bench #(.W(W), .DEPTH(1), .MODE(CH_REGISTERED)) i_b_req (
    .clk(clk), .rst(rst), .up_valid(b_qv), .up_data(b_qd), .up_ready(b_qr),
    .dn_valid(b_tv), .dn_data(b_td), .dn_ready(b_tr),
    .n_cmp(cmp[2]), .n_bad(bad[2]), .done(dn[2]));
  pb_chan_bench #(.W(W), .DEPTH(1), .MODE(CH_WIRE)) i_b_rsp (
    .clk(clk), .rst(rst), .up_valid(b_sv), .up_data(b_sd), .up_ready(b_sr),
    .dn_valid(b_iv), .dn_data(b_id), .dn_ready(b_ir),
    .n_cmp(cmp[3]), .n_bad(bad[3]), .done(dn[3]));
  pb_chan_bench #(.W(W), .DEPTH(3), .MODE(CH_REGISTERED)) i_c_req (
    .clk(clk), .rst(rst), .up_valid(c_qv), .up_data(c_qd), .up_ready(c_qr),
    .dn_valid(c_tv), .dn_data(c_td), .dn_ready(c_tr),
    .n_cmp(cmp[4]), .n_bad(bad[4]), .done(dn[4]));
  pb_chan_bench #(.W(W), .DEPTH(2), .MODE(CH_PASSACK)) i_c_rsp (
    .clk(clk), .rst(rst), .up_valid(c_sv), .up_data(c_sd), .up_ready(c_sr),
    .dn_valid(c_iv), .dn_data(c_id), .dn_ready(c_ir),
    .n_cmp(cmp[5]), .n_bad(bad[5]), .done(dn[5]));

  initial begin
    int total_cmp, total_bad;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    fork
      wait (dn[0] && dn[1] && dn[2] && dn[3] && dn[4] && dn[5]);
      begin
        repeat (20000) @(posedge clk);
        timeout = 1'b1;
      end
    join_any
    total_cmp = 0;
    total_bad = 0;
    for (int k = 0; k < 6; k++) begin
      total_cmp += cmp[k];
      total_bad += bad[k];
    end
    if (timeout) begin
      total_cmp++;
      total_bad++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total_cmp, total_bad);
    $finish;
  end

endmodule